// File: doc/BRIEF.md
# Parallel RGB Panel Output Controller

This block drives a parallel digital RGB panel or RGB-to-serial encoder. An internal timing generator produces the line and frame geometry. One pixel lasts two clock cycles, so the pixel clock runs at half the system clock. Pixels arrive on a 24-bit valid/ready stream. The block drives a pixel clock, a data-enable line, horizontal and vertical sync, 24 masked data lines, a backlight PWM line and a panel power-enable line.

A 5-bit control word switches each panel signal on or off. The clock, data-enable, backlight and power lines each have their own invert flag for active-low devices. Sync polarity is set by two separate polarity inputs. A 24-bit mask forces unused data lines low, which suits 12/15/18-bit panels and monitors with only a few colour lines.

When the power line is enabled, active video is held off for a programmable number of cycles. After that, video starts at the next frame start, and the clock and data-enable begin on the same cycle. The backlight period and duty come from plain inputs. The duty may change at any time and takes effect at the next period boundary.

Top module: `lcd_rgb_out`

## Requirements
- R1: While rst_n is low, every output, including s_ready, is low.
- R2: Control bit 0 = 0: while video runs, lcd_clk toggles every cycle, low in the first cycle of each pixel. Control bit 0 = 1: lcd_clk stays at its idle level (the value of inv_clk).
- R3: Control bit 1 = 1 holds lcd_de at its inactive level (inv_clk's counterpart, inv_de). The pixel stream and lcd_rgb keep running.
- R4: Control bit 2 = 1 enables the syncs. lcd_hs is active for H_SYNC pixels per line, starting at pixel H_ACT+H_FP. lcd_vs is active for V_SYNC whole lines, starting at line V_ACT+V_FP. The active level equals hs_pol / vs_pol (1 = active high). Control bit 2 = 0 holds both syncs at their inactive level.
- R5: Control bit 3 enables the backlight line and control bit 4 enables the power line. A disabled line sits at its inactive level. An enabled power line is driven active.
- R6: The idle or inactive level of lcd_clk, lcd_de, lcd_bl and lcd_pwr equals inv_clk, inv_de, inv_bl and inv_pwr respectively.
- R7: lcd_rgb is the pixel ANDed with rgb_mask, so no bit outside the mask is ever driven high.
- R8: With the power line enabled, no stream transfer takes place and lcd_clk/lcd_de/lcd_rgb stay idle for at least pwr_delay cycles after lcd_pwr goes active. Video then starts at the first frame start after the delay, within one frame. With the power line disabled there is no holdoff.
- R9: Video starts only at a frame start. In the first cycle lcd_de is active, lcd_clk is low, and lcd_clk rises in the next cycle.
- R10: The backlight period is bl_period+1 cycles. Within each period, lcd_bl is active for min(bl_duty, bl_period+1) cycles.
- R11: A change of bl_duty does not alter the period in progress. It applies from the next period.
- R12: s_ready is high only in the first cycle of each active pixel while video runs. A transfer happens when s_valid and s_ready are both high. lcd_rgb shows the transferred pixel in the next two cycles. If s_valid is low when s_ready is high, the pixel is shown as zero and nothing is consumed. There is no other back-pressure.
- R13: Each frame has H_ACT×V_ACT active pixels. lcd_de is active in the first H_ACT pixels of the first V_ACT lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (two cycles per pixel) |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl | input | 5 | Control word: clk off, DE off, sync on, backlight on, power on |
| inv_clk | input | 1 | Invert pixel clock |
| inv_de | input | 1 | Invert data enable |
| inv_bl | input | 1 | Invert backlight |
| inv_pwr | input | 1 | Invert power enable |
| hs_pol | input | 1 | HSYNC active level |
| vs_pol | input | 1 | VSYNC active level |
| rgb_mask | input | RGB_W | Data line mask |
| pwr_delay | input | DLY_W | Video holdoff after power-on, in cycles |
| bl_period | input | PWM_W | Backlight period minus one, in cycles |
| bl_duty | input | PWM_W | Backlight active cycles per period |
| s_valid | input | 1 | Pixel stream valid |
| s_data | input | RGB_W | Pixel stream data |
| s_ready | output | 1 | Pixel stream ready |
| lcd_clk | output | 1 | Pixel clock |
| lcd_de | output | 1 | Data enable |
| lcd_hs | output | 1 | Horizontal sync |
| lcd_vs | output | 1 | Vertical sync |
| lcd_rgb | output | RGB_W | Masked pixel data |
| lcd_bl | output | 1 | Backlight PWM |
| lcd_pwr | output | 1 | Panel power enable |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a duty write and the backlight period boundary. The bench aligns to the rising edge of lcd_bl and writes a new duty right there. It then checks that the running period keeps the old active count and the following period has the new one. The second pair is holdoff expiry and the frame-start pixel fetch. The bench enables power while video is running and counts cycles from the power edge to the first active DE. It checks that the count is no shorter than the delay and no longer than one further frame, that no stream transfer and no clock edge happen earlier, and that the clock's first rise follows DE by exactly one cycle.

// File: rtl/lcdo_pkg.sv
package lcdo_pkg;
  // control word bit positions
  localparam int CB_CLK_OFF = 0;
  localparam int CB_DE_OFF  = 1;
  localparam int CB_SYNC_ON = 2;
  localparam int CB_BL_ON   = 3;
  localparam int CB_PWR_ON  = 4;
  localparam int CTRL_W     = 5;

  typedef struct packed {
    logic pclk;         // pixel clock phase (0 = first half)
    logic pix_start;    // first cycle of a pixel
    logic frame_start;  // first cycle of pixel 0 of line 0
    logic de;
    logic hs;
    logic vs;
  } lcdo_tim_t;
endpackage

// File: rtl/lcdo_timing.sv
module lcdo_timing
  import lcdo_pkg::*;
#(
  parameter int H_ACT  = 8,
  parameter int H_FP   = 2,
  parameter int H_SYNC = 2,
  parameter int H_BP   = 2,
  parameter int V_ACT  = 4,
  parameter int V_FP   = 1,
  parameter int V_SYNC = 1,
  parameter int V_BP   = 1
) (
  input  logic      clk,
  input  logic      rst_n,
  output lcdo_tim_t tim
);
  localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int HW    = $clog2(H_TOT);
  localparam int VW    = $clog2(V_TOT);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOT - 1);
  localparam logic [HW-1:0] H_ACTC = HW'(H_ACT);
  localparam logic [HW-1:0] HS_BEG = HW'(H_ACT + H_FP);
  localparam logic [HW-1:0] HS_END = HW'(H_ACT + H_FP + H_SYNC);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOT - 1);
  localparam logic [VW-1:0] V_ACTC = VW'(V_ACT);
  localparam logic [VW-1:0] VS_BEG = VW'(V_ACT + V_FP);
  localparam logic [VW-1:0] VS_END = VW'(V_ACT + V_FP + V_SYNC);

  logic          phase;
  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 1'b0;
      h_cnt <= '0;
      v_cnt <= '0;
    end else begin
      phase <= ~phase;
      if (phase) begin
        if (h_cnt == H_LAST) begin
          h_cnt <= '0;
          v_cnt <= (v_cnt == V_LAST) ? '0 : v_cnt + 1'b1;
        end else begin
          h_cnt <= h_cnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    tim.pclk        = phase;
    tim.pix_start   = ~phase;
    tim.frame_start = ~phase && (h_cnt == '0) && (v_cnt == '0);
    tim.de          = (h_cnt < H_ACTC) && (v_cnt < V_ACTC);
    tim.hs          = (h_cnt >= HS_BEG) && (h_cnt < HS_END);
    tim.vs          = (v_cnt >= VS_BEG) && (v_cnt < VS_END);
  end

  // lines advance only when the pixel counter wraps
  p_line_step_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (v_cnt != $past(v_cnt)) |-> (h_cnt == '0));
endmodule

// File: rtl/lcdo_power.sv
module lcdo_power #(
  parameter int DLY_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DLY_W-1:0] delay,
  output logic             released
);
  logic [DLY_W-1:0] cnt;
  logic             done;

  assign done     = (cnt >= delay);
  assign released = !en || done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!en)   cnt <= '0;
    else if (!done) cnt <= cnt + 1'b1;
  end

  // once the delay has elapsed the count freezes while power stays on
  p_count_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && done) |=> (!en || (cnt == $past(cnt))));
endmodule

// File: rtl/lcdo_backlight.sv
module lcdo_backlight #(
  parameter int PWM_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PWM_W-1:0] period,
  input  logic [PWM_W-1:0] duty,
  output logic             pwm
);
  logic [PWM_W-1:0] cnt;
  logic [PWM_W-1:0] duty_q;
  logic             wrap;

  assign wrap = (cnt >= period);
  assign pwm  = (cnt < duty_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      duty_q <= '0;
    end else if (wrap) begin
      cnt    <= '0;
      duty_q <= duty;
    end else begin
      cnt    <= cnt + 1'b1;
    end
  end

  // the working duty only moves at a period boundary
  p_duty_at_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q != $past(duty_q)) |-> (cnt == '0));
endmodule

// File: rtl/lcd_rgb_out.sv
module lcd_rgb_out
  import lcdo_pkg::*;
#(
  parameter int H_ACT  = 8,
  parameter int H_FP   = 2,
  parameter int H_SYNC = 2,
  parameter int H_BP   = 2,
  parameter int V_ACT  = 4,
  parameter int V_FP   = 1,
  parameter int V_SYNC = 1,
  parameter int V_BP   = 1,
  parameter int RGB_W  = 24,
  parameter int DLY_W  = 24,
  parameter int PWM_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              inv_clk,
  input  logic              inv_de,
  input  logic              inv_bl,
  input  logic              inv_pwr,
  input  logic              hs_pol,
  input  logic              vs_pol,
  input  logic [RGB_W-1:0]  rgb_mask,
  input  logic [DLY_W-1:0]  pwr_delay,
  input  logic [PWM_W-1:0]  bl_period,
  input  logic [PWM_W-1:0]  bl_duty,
  input  logic              s_valid,
  input  logic [RGB_W-1:0]  s_data,
  output logic              s_ready,
  output logic              lcd_clk,
  output logic              lcd_de,
  output logic              lcd_hs,
  output logic              lcd_vs,
  output logic [RGB_W-1:0]  lcd_rgb,
  output logic              lcd_bl,
  output logic              lcd_pwr
);
  lcdo_tim_t tim;
  logic      released;
  logic      pwm;
  logic      video_on;
  logic      video_nxt;
  logic      active_px;
  logic [RGB_W-1:0] pix_hold, pix_now, rgb_q;
  logic clk_q, de_q, hs_q, vs_q, bl_q, pwr_q;

  lcdo_timing #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .tim(tim)
  );

  lcdo_power #(.DLY_W(DLY_W)) u_power (
    .clk(clk), .rst_n(rst_n), .en(ctrl[CB_PWR_ON]),
    .delay(pwr_delay), .released(released)
  );

  lcdo_backlight #(.PWM_W(PWM_W)) u_backlight (
    .clk(clk), .rst_n(rst_n), .period(bl_period),
    .duty(bl_duty), .pwm(pwm)
  );

  // video may only switch on at a frame start; it drops at once on holdoff
  assign video_nxt = rst_n && released && (tim.frame_start || video_on);
  assign active_px = video_nxt && tim.de;
  assign s_ready   = active_px && tim.pix_start;
  assign pix_now   = s_ready ? (s_valid ? s_data : '0) : pix_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      video_on <= 1'b0;
      pix_hold <= '0;
      rgb_q    <= '0;
      clk_q    <= 1'b0;
      de_q     <= 1'b0;
      hs_q     <= 1'b0;
      vs_q     <= 1'b0;
      bl_q     <= 1'b0;
      pwr_q    <= 1'b0;
    end else begin
      video_on <= video_nxt;
      pix_hold <= pix_now;
      rgb_q    <= active_px ? (pix_now & rgb_mask) : '0;
      clk_q    <= (video_nxt && !ctrl[CB_CLK_OFF] && tim.pclk) ^ inv_clk;
      de_q     <= (active_px && !ctrl[CB_DE_OFF]) ^ inv_de;
      hs_q     <= (ctrl[CB_SYNC_ON] && tim.hs) ~^ hs_pol;
      vs_q     <= (ctrl[CB_SYNC_ON] && tim.vs) ~^ vs_pol;
      bl_q     <= (ctrl[CB_BL_ON] && pwm) ^ inv_bl;
      pwr_q    <= ctrl[CB_PWR_ON] ^ inv_pwr;
    end
  end

  assign lcd_clk = clk_q;
  assign lcd_de  = de_q;
  assign lcd_hs  = hs_q;
  assign lcd_vs  = vs_q;
  assign lcd_rgb = rgb_q;
  assign lcd_bl  = bl_q;
  assign lcd_pwr = pwr_q;

  // no pixel is fetched while the power holdoff is running
  p_no_fetch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> released);

  // panel lines stay idle whenever video is off
  p_idle_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !video_on) |->
      ((lcd_clk == $past(inv_clk)) && (lcd_de == $past(inv_de)) && (lcd_rgb == '0)));

  // video switches on only right after a frame start
  p_start_at_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(video_on) |-> $past(tim.frame_start));

  // masked data lines never go high
  p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_rgb & ~$past(rgb_mask)) == '0);
endmodule

// File: tb/lcd_rgb_out_tb.sv
`timescale 1ns/1ps
module lcd_rgb_out_tb;
  localparam int H_ACT = 8, H_FP = 2, H_SYNC = 2, H_BP = 2;
  localparam int V_ACT = 4, V_FP = 1, V_SYNC = 1, V_BP = 1;
  localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int FRAME = 2 * H_TOT * V_TOT;
  localparam int E_DE  = 2 * H_ACT * V_ACT;
  localparam int E_CLK = FRAME / 2;
  localparam int E_HS  = 2 * H_SYNC * V_TOT;
  localparam int E_VS  = 2 * H_TOT * V_SYNC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  ctrl = 5'h04;
  logic        inv_clk = 0, inv_de = 0, inv_bl = 0, inv_pwr = 0;
  logic        hs_pol = 1, vs_pol = 1;
  logic [23:0] rgb_mask = 24'hFFFFFF;
  logic [23:0] pwr_delay = 24'd0;
  logic [23:0] bl_period = 24'd9;
  logic [23:0] bl_duty = 24'd3;
  logic        s_valid = 1'b1;
  logic [23:0] s_data;
  logic        s_ready, lcd_clk, lcd_de, lcd_hs, lcd_vs, lcd_bl, lcd_pwr;
  logic [23:0] lcd_rgb;

  int n_chk = 0;
  int n_fail = 0;
  int kidx = 0;

  always #2.5 clk = ~clk;

  lcd_rgb_out u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl),
    .inv_clk(inv_clk), .inv_de(inv_de), .inv_bl(inv_bl), .inv_pwr(inv_pwr),
    .hs_pol(hs_pol), .vs_pol(vs_pol), .rgb_mask(rgb_mask),
    .pwr_delay(pwr_delay), .bl_period(bl_period), .bl_duty(bl_duty),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .lcd_clk(lcd_clk), .lcd_de(lcd_de), .lcd_hs(lcd_hs), .lcd_vs(lcd_vs),
    .lcd_rgb(lcd_rgb), .lcd_bl(lcd_bl), .lcd_pwr(lcd_pwr)
  );

  function automatic logic [23:0] pix(input int k);
    return {k[7:0], 8'(k * 3), ~k[7:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({s_ready, lcd_clk, lcd_de, lcd_hs, lcd_vs, lcd_bl, lcd_pwr} == 7'd0 && lcd_rgb == '0,
        "R1 outputs low in reset", {s_ready, lcd_clk, lcd_de, lcd_hs, lcd_vs, lcd_bl, lcd_pwr}, 0);
    rst_n = 1'b1;
  endtask

  // one full frame of stream and timing checks
  task automatic t_frame(input logic [23:0] m, input bit v, input int e_de, input int e_clk,
                         input int e_hs, input int e_vs, input string tag);
    int n_de = 0, n_clk = 0, n_hs = 0, n_vs = 0, n_rdy = 0, bad = 0;
    bit flag = 0, prev;
    logic [23:0] exp_px = '0;
    rgb_mask = m;
    s_valid  = v;
    repeat (4) @(negedge clk);
    prev = lcd_clk ^ inv_clk;
    for (int i = 0; i < FRAME; i++) begin
      @(negedge clk);
      if (flag) begin
        if (lcd_rgb !== exp_px) bad++;
        kidx++;
        s_data = pix(kidx);
        flag = 0;
      end
      if (s_ready) begin
        n_rdy++;
        exp_px = v ? (s_data & m) : '0;
        flag = 1;
      end
      if (lcd_de ^ inv_de) n_de++;
      if ((lcd_clk ^ inv_clk) && !prev) n_clk++;
      prev = lcd_clk ^ inv_clk;
      if (lcd_hs == hs_pol) n_hs++;
      if (lcd_vs == vs_pol) n_vs++;
    end
    chk(bad == 0, {tag, " R12 R7 pixel data"}, bad, 0);
    chk(n_rdy == H_ACT * V_ACT, {tag, " R12 one fetch per pixel"}, n_rdy, H_ACT * V_ACT);
    chk(n_de == e_de, {tag, " R13 R3 DE cycles"}, n_de, e_de);
    chk(n_clk == e_clk, {tag, " R2 clock rises"}, n_clk, e_clk);
    chk(n_hs == e_hs, {tag, " R4 hsync cycles"}, n_hs, e_hs);
    chk(n_vs == e_vs, {tag, " R4 vsync cycles"}, n_vs, e_vs);
  endtask

  task automatic t_static_inv();
    int bad = 0;
    ctrl = 5'h03; inv_clk = 1; inv_de = 1; inv_bl = 1; inv_pwr = 1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < FRAME; i++) begin
      @(negedge clk);
      if (!(lcd_clk && lcd_de && lcd_bl && lcd_pwr)) bad++;
    end
    chk(bad == 0, "R6 R5 disabled inverted lines idle high", bad, 0);
    inv_clk = 0; inv_de = 0; inv_bl = 0; inv_pwr = 0;
  endtask

  task automatic t_pwm(input int duty, input bit inv, input int e_on);
    int on = 0;
    ctrl = 5'h0C; inv_bl = inv; bl_duty = 24'(duty);
    repeat (30) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (lcd_bl) on++;
    end
    chk(on == e_on, "R10 backlight active cycles per period", on, e_on);
    inv_bl = 0;
  endtask

  task automatic t_duty_boundary();
    int on1 = 0, on2 = 0, guard = 0;
    bit prev;
    ctrl = 5'h0C; bl_duty = 24'd3;
    repeat (30) @(negedge clk);
    prev = lcd_bl;
    @(negedge clk);
    while (!(lcd_bl && !prev) && guard < 50) begin
      prev = lcd_bl;
      @(negedge clk);
      guard++;
    end
    bl_duty = 24'd7;  // written right at the period start
    for (int i = 0; i < 10; i++) begin
      if (lcd_bl) on1++;
      @(negedge clk);
    end
    for (int i = 0; i < 10; i++) begin
      if (lcd_bl) on2++;
      @(negedge clk);
    end
    chk(on1 == 3, "R11 running period keeps old duty", on1, 3);
    chk(on2 == 7, "R11 next period takes new duty", on2, 7);
  endtask

  task automatic t_power();
    localparam int D = 60;
    int first = -1, early = 0;
    logic clk_at = 1'b1, clk_next = 1'b0;
    ctrl = 5'h04; pwr_delay = 24'(D);
    repeat (4) @(negedge clk);
    ctrl = 5'h14;
    @(negedge clk);
    chk(lcd_pwr == 1'b1, "R5 power line driven", lcd_pwr, 1);
    for (int k = 0; k < D + FRAME + 10; k++) begin
      if (first < 0) begin
        if (lcd_de) begin
          first = k;
          clk_at = lcd_clk;
        end else begin
          if (lcd_clk) early++;
          if (s_ready && k < D - 1) early++;
        end
      end else if (k == first + 1) begin
        clk_next = lcd_clk;
      end
      @(negedge clk);
    end
    chk(first >= D, "R8 holdoff not shorter than delay", first, D);
    chk(first >= 0 && first <= D + FRAME + 2, "R8 video starts within a frame", first, D);
    chk(early == 0, "R8 no clock or fetch during holdoff", early, 0);
    chk(clk_at == 1'b0, "R9 clock low in first DE cycle", clk_at, 0);
    chk(clk_next == 1'b1, "R9 clock rises one cycle after DE", clk_next, 1);
  endtask

  initial begin
    s_data = pix(0);
    t_reset();
    ctrl = 5'h04;
    t_frame(24'hFFFFFF, 1'b1, E_DE, E_CLK, E_HS, E_VS, "base");
    t_frame(24'h0F0F0F, 1'b1, E_DE, E_CLK, E_HS, E_VS, "mask R7");
    t_frame(24'hFFFFFF, 1'b0, E_DE, E_CLK, E_HS, E_VS, "underrun R12");
    ctrl = 5'h07; hs_pol = 0; vs_pol = 0;
    t_frame(24'hFFFFFF, 1'b1, 0, 0, E_HS, E_VS, "clk+de off R2 R3");
    ctrl = 5'h00; hs_pol = 1; vs_pol = 1;
    t_frame(24'hFFFFFF, 1'b1, E_DE, E_CLK, 0, 0, "sync off R4");
    ctrl = 5'h04; inv_clk = 1; inv_de = 1;
    t_frame(24'hFFFFFF, 1'b1, E_DE, E_CLK, E_HS, E_VS, "inverted R6");
    inv_clk = 0; inv_de = 0;
    t_static_inv();
    t_pwm(3, 1'b0, 3);
    t_pwm(0, 1'b0, 0);
    t_pwm(15, 1'b0, 10);
    t_pwm(3, 1'b1, 7);
    t_duty_boundary();
    t_power();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule